// File: doc/BRIEF.md
# VID output select multiplexer

This block drives a 5-bit voltage-identification code and one auxiliary level toward a supply controller. The code comes either from a 5-bit parallel input port or from one of two 8-bit setting registers. Three things decide the source: an external select pin, an active-low override pin, and a 2-bit source field that both registers share.

The serial interface logic passes in register writes one byte at a time through a write strobe, a register index and a data byte. It then raises a commit strobe when it sees the stop condition on the bus. Written bytes are staged and stay invisible until that commit. The selection therefore never changes partway through a transaction.

The auxiliary output is transparent while the select pin is low. It holds its last value while the pin is high.

Top module: `vid_out_select`

## Requirements
- R1: While `selPin` is 1, `yOut` equals `portIn` in the same cycle, whatever the register contents.
- R2: While `selPin` is 0, `overrideN` is 1 and the field-valid flag is set, the active source field decides `yOut`: 2'b01 gives register A bits [4:0], 2'b10 gives register B bits [4:0], and 2'b00 or 2'b11 gives `portIn`.
- R3: While `selPin` is 0 and `overrideN` is 0, `yOut` is 5'b00000 and `auxOut` is 0.
- R4: Reset clears the field-valid flag. While the flag is clear, `yOut` follows `portIn` whatever the field holds. The flag is set by the first commit that follows a write to register A or register B, and it then stays set until reset.
- R5: A write (`wrEn`=1) only stages data. Outputs change only on a `commitStb` clock edge, which copies every staged value to the active copy. A write in the same cycle as a commit waits for the next commit.
- R6: Register layout: bits [4:0] hold the code, bit 5 holds the auxiliary bit, and bits [7:6] hold the shared source field. A write to either register (`wrAddr` 0 = A, 1 = B) replaces the shared field.
- R7: With `selPin` 0 and `overrideN` 1, `auxOut` equals bit 5 of the register that the active field selects. It is 0 when the field is not valid or selects the port.
- R8: `auxOut` follows its live value while `selPin` is 0. While `selPin` is 1 it holds the live value seen at the last clock edge where `selPin` was 0.
- R9: Writes with `wrAddr` 2 or 3 are ignored. They stage nothing and do not make the field valid.
- R10: During and right after reset, `yOut` equals `portIn` and `auxOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe from the serial interface |
| wrAddr | input | 2 | Register index: 0 = A, 1 = B, others ignored |
| wrData | input | 8 | Register byte to stage |
| commitStb | input | 1 | Stop-condition commit strobe |
| selPin | input | 1 | External select: 1 = parallel port, 0 = register path |
| overrideN | input | 1 | Active-low override forcing outputs low on the register path |
| portIn | input | 5 | Parallel input code |
| yOut | output | 5 | Voltage-identification code |
| auxOut | output | 1 | Auxiliary level |

## Verification
A behavioural model predicts both outputs every cycle. The directed phases come first:
- Writes to the unused indices, followed by a commit, show that those writes are ignored and that the valid flag stays clear.
- Staged writes with no commit show the commit gating.
- Each of the four field codes, with distinct register data, shows that the A, B and port paths are selected apart from one another.
- Raising `selPin` with a live auxiliary 1, and then committing a 0 while the pin is high, separates the hold behaviour from plain transparency.
- Override pulses on both sides of the select pin show when forcing applies.

A long random phase then mixes writes, commits, pin toggles and port changes to reach orderings that the directed phases skip.

// File: rtl/vid_sel_pkg.sv
package vid_sel_pkg;
  typedef enum logic [1:0] {
    FLD_PORT_LO = 2'b00,
    FLD_REG_A   = 2'b01,
    FLD_REG_B   = 2'b10,
    FLD_PORT_HI = 2'b11
  } srcField_e;

  typedef struct packed {
    logic stageA;
    logic stageB;
    logic commit;
    logic markValid;
  } ctrlStb_t;
endpackage

// File: rtl/vid_sel_ctrl.sv
module vid_sel_ctrl
  import vid_sel_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              commitStb,
  output ctrlStb_t          stb,
  output logic              fieldValid
);
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(1);

  logic pendWritten;

  always_comb begin
    stb.stageA    = wrEn && (wrAddr == ADDR_A);
    stb.stageB    = wrEn && (wrAddr == ADDR_B);
    stb.commit    = commitStb;
    stb.markValid = commitStb && pendWritten;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWritten <= 1'b0;
      fieldValid  <= 1'b0;
    end else begin
      if (stb.stageA || stb.stageB) pendWritten <= 1'b1;
      if (stb.markValid)            fieldValid  <= 1'b1;
    end
  end

  // R4: once set the flag stays set
  p_valid_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    fieldValid |=> fieldValid);

  // R9/R4: the flag only rises after a commit edge
  p_valid_needs_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fieldValid) |-> $past(commitStb));
endmodule

// File: rtl/vid_sel_datapath.sv
module vid_sel_datapath
  import vid_sel_pkg::*;
#(
  parameter int DATA_W = 5,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              fieldValid,
  input  logic [REG_W-1:0]  wrData,
  input  logic              selPin,
  input  logic              overrideN,
  input  logic [DATA_W-1:0] portIn,
  output logic [DATA_W-1:0] yOut,
  output logic              auxOut
);
  localparam int AUX_POS   = DATA_W;
  localparam int SLOT_W    = DATA_W + 1;
  localparam int FLD_LSB   = REG_W - 2;
  localparam int NUM_SLOTS = 2;

  logic [SLOT_W-1:0] pendSlot [NUM_SLOTS];
  logic [SLOT_W-1:0] actSlot  [NUM_SLOTS];
  logic [1:0]        pendFld, actFld;
  logic              auxHeld, auxLive, useReg, slotIdx;
  srcField_e         fld;
  logic [DATA_W-1:0] regCode;
  logic              regAux;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic stageThis;
    assign stageThis = (g == 0) ? stb.stageA : stb.stageB;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendSlot[g] <= '0;
        actSlot[g]  <= '0;
      end else begin
        if (stageThis)  pendSlot[g] <= wrData[SLOT_W-1:0];
        if (stb.commit) actSlot[g]  <= pendSlot[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendFld <= '0;
      actFld  <= '0;
    end else begin
      if (stb.stageA || stb.stageB) pendFld <= wrData[REG_W-1:FLD_LSB];
      if (stb.commit)               actFld  <= pendFld;
    end
  end

  always_comb begin
    fld     = srcField_e'(actFld);
    useReg  = fieldValid && (fld == FLD_REG_A || fld == FLD_REG_B);
    slotIdx = (fld == FLD_REG_B);
    regCode = actSlot[slotIdx][DATA_W-1:0];
    regAux  = actSlot[slotIdx][AUX_POS];
    auxLive = overrideN && useReg && regAux;
    if (selPin)          yOut = portIn;
    else if (!overrideN) yOut = '0;
    else if (useReg)     yOut = regCode;
    else                 yOut = portIn;
    auxOut = selPin ? auxHeld : auxLive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        auxHeld <= 1'b0;
    else if (!selPin) auxHeld <= auxLive;
  end

  p_pin_passthru_r1: assert property (@(posedge clk) disable iff (!rstN)
    selPin |-> (yOut == portIn));

  p_override_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!selPin && !overrideN) |-> (yOut == '0 && !auxOut));

  p_invalid_port_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!fieldValid && !selPin && overrideN) |-> (yOut == portIn));

  p_hold_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(actFld));

  p_aux_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selPin && $past(selPin)) |-> $stable(auxOut));
endmodule

// File: rtl/vid_out_select.sv
module vid_out_select
  import vid_sel_pkg::*;
#(
  parameter int DATA_W = 5,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              commitStb,
  input  logic              selPin,
  input  logic              overrideN,
  input  logic [DATA_W-1:0] portIn,
  output logic [DATA_W-1:0] yOut,
  output logic              auxOut
);
  ctrlStb_t stb;
  logic     fieldValid;

  vid_sel_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .commitStb(commitStb), .stb(stb), .fieldValid(fieldValid)
  );

  vid_sel_datapath #(.DATA_W(DATA_W), .REG_W(REG_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .fieldValid(fieldValid),
    .wrData(wrData), .selPin(selPin), .overrideN(overrideN),
    .portIn(portIn), .yOut(yOut), .auxOut(auxOut)
  );
endmodule

// File: tb/tb_vid_out_select.sv
`timescale 1ns/1ps
module tb_vid_out_select;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       commitStb = 1'b0;
  logic       selPin = 1'b0;
  logic       overrideN = 1'b1;
  logic [4:0] portIn = 5'h15;
  logic [4:0] yOut;
  logic       auxOut;

  vid_out_select dut (.*);

  always #2 clk = ~clk;

  int    nVec = 0, nBad = 0;
  bit    done = 1'b0;
  string curReq = "R10";

  // behavioural reference state
  int mPend[2], mAct[2];
  int mPendF, mActF;
  bit mValid, mSeen, mHeld;

  function automatic bit useRegF();
    return mValid && (mActF == 1 || mActF == 2);
  endfunction
  function automatic int pickIdx();
    return (mActF == 2) ? 1 : 0;
  endfunction
  function automatic bit liveAux();
    return overrideN && useRegF() && ((mAct[pickIdx()] >> 5) & 1);
  endfunction
  function automatic int expY();
    if (selPin) return portIn;
    if (!overrideN) return 0;
    if (useRegF()) return mAct[pickIdx()] & 31;
    return portIn;
  endfunction
  function automatic bit expAux();
    return selPin ? mHeld : liveAux();
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend[0] = 0; mPend[1] = 0; mAct[0] = 0; mAct[1] = 0;
      mPendF = 0; mActF = 0; mValid = 0; mSeen = 0; mHeld = 0;
    end else begin
      bit newHeld;
      newHeld = selPin ? mHeld : liveAux();
      if (commitStb) begin
        if (mSeen) mValid = 1;
        mAct[0] = mPend[0]; mAct[1] = mPend[1]; mActF = mPendF;
      end
      if (wrEn && wrAddr < 2) begin
        mPend[wrAddr] = wrData & 63;
        mPendF = (wrData >> 6) & 3;
        mSeen = 1;
      end
      mHeld = newHeld;
    end
  end

  task automatic tick();
    @(negedge clk);
    nVec++;
    if (yOut !== 5'(expY()) || auxOut !== expAux()) begin
      nBad++;
      $display("FAIL %s: y=%h aux=%b expected y=%h aux=%b", curReq,
               yOut, auxOut, 5'(expY()), expAux());
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic doCommit();
    commitStb = 1'b1;
    tick();
    commitStb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    // R10: reset state
    curReq = "R10";
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R9: unused indices are ignored and do not validate the field
    curReq = "R9";
    doWrite(2'd2, 8'h5A);
    doWrite(2'd3, 8'h9F);
    doCommit();
    idle(2);

    // R5: staged write without commit leaves outputs alone
    curReq = "R5";
    doWrite(2'd0, 8'h6A);           // field 01, aux 1, code 0A
    doWrite(2'd1, 8'h13);           // field 00, code 13
    doWrite(2'd0, 8'h6A);           // field back to 01
    portIn = 5'h04;
    idle(3);

    // R4: the first commit after a valid write sets the flag
    curReq = "R4";
    doCommit();
    idle(1);

    // R2/R6: every field code, distinct data in A and B
    curReq = "R2";
    doWrite(2'd1, 8'hB1);           // field 10, aux 1, code 11
    doCommit(); idle(2);
    doWrite(2'd0, 8'h0C);           // field 00
    doCommit(); idle(2);
    doWrite(2'd1, 8'hD5);           // field 11
    doCommit(); idle(2);
    curReq = "R6";
    doWrite(2'd0, 8'h5E);           // field 01, aux 0, code 1E
    doCommit(); idle(2);

    // R5: write in the same cycle as a commit waits
    curReq = "R5";
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'h63; commitStb = 1'b1;
    tick();
    wrEn = 1'b0; commitStb = 1'b0;
    idle(2);
    doCommit(); idle(1);

    // R1: pin passthrough
    curReq = "R1";
    selPin = 1'b1; portIn = 5'h1B;
    idle(2);
    portIn = 5'h02; idle(1);
    selPin = 1'b0; idle(1);

    // R3: override on register path, no effect with pin high
    curReq = "R3";
    overrideN = 1'b0; idle(2);
    selPin = 1'b1; idle(2);
    selPin = 1'b0; idle(1);
    overrideN = 1'b1; idle(1);

    // R7/R8: aux transparency and hold
    curReq = "R7";
    doWrite(2'd0, 8'h60); doCommit(); idle(1);   // aux 1 live
    curReq = "R8";
    selPin = 1'b1; idle(2);
    doWrite(2'd0, 8'h40); doCommit(); idle(2);   // aux 0 committed, held 1
    selPin = 1'b0; idle(2);
    selPin = 1'b1; idle(2);

    // random mix
    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      wrEn = (r < 4); wrAddr = 2'($urandom_range(0, 3));
      wrData = 8'($urandom);
      commitStb = (r == 5 || r == 6);
      if (r == 7) selPin = ~selPin;
      if (r == 8) overrideN = ($urandom_range(0, 3) != 0);
      if (r >= 9) portIn = 5'($urandom);
      tick();
    end
    wrEn = 1'b0; commitStb = 1'b0;
    idle(2);
    finishRun();
  end
endmodule